// File: doc/BRIEF.md
# Keyboard Interrupt Flag Controller

This block watches a port of key inputs and records an event for each key in a sticky flag. Each input is first retimed by a two-stage synchronizer. Per key, a mode bit picks how the event is detected. In level detection, the flag sets in every cycle in which the retimed input equals that key's polarity bit. In edge detection, it sets only on a transition toward the polarity value. One interrupt request line stays high while any flag whose enable bit is set remains pending.

Software reaches four registers through a plain register port: flags, enable, polarity and mode. A read has no side effect, so reading the flag register never clears it. Software clears flags by writing the flag register: a 0 clears that bit and a 1 keeps it. Clearing one bit at a time gives one service per pending key, and writing all zeros clears every flag at once. The register port carries control traffic, not a data stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `reg_wr` is high, and `reg_rdata` is loaded at the edge where `reg_rd` is high.

Top module: `kbi_flag_ctrl`

## Requirements
- R1: After reset the flag, enable, polarity and mode registers read 0x00, `irq` is low and `reg_rdata` is 0x00.
- R2: Register addresses are 0 = flags, 1 = enable, 2 = polarity, 3 = mode. A write with `reg_wr` high updates the enable, polarity or mode register at that edge. A read with `reg_rd` high loads that register's pre-edge value into `reg_rdata`, which holds until the next read.
- R3: A change on a key input can first affect its flag at the third rising edge after the change (two synchronizer stages, then the flag register), and `irq` follows in the same cycle.
- R4: With mode bit 0 (level), a flag sets at every edge where the synchronized input equals the polarity bit, so it comes back after a clear while the level persists.
- R5: With mode bit 1 (edge), a flag sets only when the synchronized input moves from not-equal to equal to the polarity bit. A held level or a move away from the polarity value sets nothing.
- R6: Reading any register, the flag register included, leaves every flag unchanged.
- R7: Writing the flag register clears each bit written as 0 and keeps each bit written as 1.
- R8: When a set condition and a clear of the same flag meet at one edge, the flag stays set.
- R9: `irq` is high exactly when some flag bit and its enable bit are both 1. A flag with enable 0 still sets and reads back but does not raise `irq`.
- R10: Writing 0x00 to the flag register clears all flags whose set condition is not active, and `irq` drops when none remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | KEYS | Raw key inputs, asynchronous |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | KEYS | Write data |
| reg_rdata | output | KEYS | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that flags survive any cycle without a flag write, that a set condition always lands in the flag register even while a clear is written, that cleared bits fall unless set in the same edge, that edge mode never sets on a stable input, and that `irq` holds without a write. Only the bench scenarios can show the three-edge input latency, the re-set of level flags after a clear, the one-at-a-time clearing sequence and the masking by the enable register. A random phase compares `irq` and every read against a cycle model built from the requirements.

// File: rtl/kbi_pkg.sv
package kbi_pkg;
  typedef enum logic [1:0] {
    KB_FLAGS  = 2'd0,
    KB_ENABLE = 2'd1,
    KB_POLAR  = 2'd2,
    KB_MODE   = 2'd3
  } kb_reg_e;
endpackage

// File: rtl/kbi_sync.sv
module kbi_sync #(
  parameter int KEYS = 8,
  parameter int STAGES = 2,
  parameter logic [KEYS-1:0] IDLE = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] key_i,
  output logic [KEYS-1:0] sync_o
);
  for (genvar i = 0; i < KEYS; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{IDLE[i]}};
      else        chain_q <= {chain_q[STAGES-2:0], key_i[i]};
    end
    assign sync_o[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/kbi_detect.sv
module kbi_detect #(
  parameter int KEYS = 8,
  parameter logic [KEYS-1:0] IDLE = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] sync_i,
  input  logic [KEYS-1:0] pol_i,
  input  logic [KEYS-1:0] mode_i,
  output logic [KEYS-1:0] set_o
);
  logic [KEYS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= sync_i;
  end

  for (genvar i = 0; i < KEYS; i++) begin : g_bit
    logic hit_now, hit_before;
    assign hit_now    = (sync_i[i] == pol_i[i]);
    assign hit_before = (prev_q[i] == pol_i[i]);
    assign set_o[i]   = mode_i[i] ? (hit_now && !hit_before) : hit_now;

    // R5: edge mode never sets on an unchanged input
    p_edge_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[i] && $stable(sync_i[i]) && $stable(pol_i[i])) |-> !set_o[i]);
  end
endmodule

// File: rtl/kbi_flags.sv
module kbi_flags #(
  parameter int KEYS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] set_i,
  input  logic            wr_i,
  input  logic [KEYS-1:0] wdata_i,
  output logic [KEYS-1:0] flags_o
);
  logic [KEYS-1:0] flags_q, keep;

  assign keep = wr_i ? wdata_i : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & keep) | set_i;
  end

  assign flags_o = flags_q;

  // R6: without a flag write no flag ever drops
  p_no_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R8: a set condition always lands, even against a clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags_q & $past(set_i)) == $past(set_i)));
  // R7: bits written as 0 fall unless set at that edge
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((flags_q & ~$past(wdata_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/kbi_flag_ctrl.sv
module kbi_flag_ctrl #(
  parameter int KEYS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KEYS-1:0] key_in,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [KEYS-1:0] reg_wdata,
  output logic [KEYS-1:0] reg_rdata,
  output logic            irq
);
  import kbi_pkg::*;

  localparam logic [KEYS-1:0] IDLE = '1;

  kb_reg_e         sel;
  logic [KEYS-1:0] sync_v, set_v, flags_v;
  logic [KEYS-1:0] en_q, pol_q, mode_q, rd_q, rd_mux;
  logic            flag_wr;

  assign sel     = kb_reg_e'(reg_addr);
  assign flag_wr = reg_wr && (sel == KB_FLAGS);

  kbi_sync #(.KEYS(KEYS), .STAGES(2), .IDLE(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .key_i(key_in), .sync_o(sync_v));

  kbi_detect #(.KEYS(KEYS), .IDLE(IDLE)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_v), .pol_i(pol_q),
    .mode_i(mode_q), .set_o(set_v));

  kbi_flags #(.KEYS(KEYS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .wr_i(flag_wr),
    .wdata_i(reg_wdata), .flags_o(flags_v));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (reg_wr) begin
      case (sel)
        KB_ENABLE: en_q   <= reg_wdata;
        KB_POLAR:  pol_q  <= reg_wdata;
        KB_MODE:   mode_q <= reg_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      KB_FLAGS:  rd_mux = flags_v;
      KB_ENABLE: rd_mux = en_q;
      KB_POLAR:  rd_mux = pol_q;
      default:   rd_mux = mode_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (reg_rd) rd_q <= rd_mux;
  end

  assign reg_rdata = rd_q;
  assign irq       = |(flags_v & en_q);

  // R9: a pending enabled request persists until software writes
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq);
endmodule

// File: tb/kbi_flag_ctrl_tb_top.sv
module kbi_flag_ctrl_tb_top;
  localparam int KEYS = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [KEYS-1:0] key_in = '1;
  logic [1:0]      reg_addr = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [KEYS-1:0] reg_wdata = '0;
  logic [KEYS-1:0] reg_rdata;
  logic            irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  kbi_flag_ctrl #(.KEYS(KEYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .key_in(key_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  // Cycle model built from the requirements
  logic [KEYS-1:0] m_s1, m_s2, m_prv, m_flg, m_en, m_pol, m_mode, m_rd;

  function automatic logic [KEYS-1:0] f_set(input logic [KEYS-1:0] cur, prv,
                                            input logic [KEYS-1:0] pol, mode);
    logic [KEYS-1:0] r;
    for (int i = 0; i < KEYS; i++)
      r[i] = mode[i] ? ((cur[i] == pol[i]) && (prv[i] != pol[i])) : (cur[i] == pol[i]);
    return r;
  endfunction

  function automatic logic [KEYS-1:0] f_read(input logic [1:0] a);
    case (a)
      2'd0: return m_flg;
      2'd1: return m_en;
      2'd2: return m_pol;
      default: return m_mode;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_prv <= '1; m_flg <= '0;
      m_en <= '0; m_pol <= '0; m_mode <= '0; m_rd <= '0;
    end else begin
      m_s1 <= key_in; m_s2 <= m_s1; m_prv <= m_s2;
      m_flg <= (m_flg & ((reg_wr && reg_addr == 2'd0) ? reg_wdata : '1))
               | f_set(m_s2, m_prv, m_pol, m_mode);
      if (reg_wr && reg_addr == 2'd1) m_en <= reg_wdata;
      if (reg_wr && reg_addr == 2'd2) m_pol <= reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_mode <= reg_wdata;
      if (reg_rd) m_rd <= f_read(reg_addr);
    end
  end

  task automatic chk(input string req, input logic [KEYS-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock edge, then compare against the model
  task automatic tick();
    @(negedge clk);
    chk("R9 irq", {7'd0, irq}, {7'd0, |(m_flg & m_en)});
    chk("R2 rdata", reg_rdata, m_rd);
    reg_wr = 1'b0; reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [KEYS-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick();
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [KEYS-1:0] exp, input string req);
    reg_addr = a; reg_rd = 1'b1; tick();
    chk(req, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    for (int a = 0; a < 4; a++) rd_chk(a[1:0], 8'h00, "R1 reg");
    // R2 register write/read back
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'hF0);
    rd_chk(2'd1, 8'hA5, "R2 enable");
    rd_chk(2'd2, 8'h3C, "R2 polarity");
    rd_chk(2'd3, 8'hF0, "R2 mode");
    wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
    // R3 latency of three edges
    key_in = 8'hFE;
    tick(); chk("R3 edge1", {7'd0, irq}, 8'h00);
    tick(); chk("R3 edge2", {7'd0, irq}, 8'h00);
    tick(); chk("R3 edge3", {7'd0, irq}, 8'h01);
    // R8 clear loses to a held level
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h01, "R8 set wins");
    // R4 level released, then clear sticks
    key_in = 8'hFF; ticks(3);
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h00, "R4 released");
    // R5 edge mode
    wr(2'd3, 8'hFF);
    key_in = 8'hFD; ticks(4);
    rd_chk(2'd0, 8'h02, "R5 edge set");
    wr(2'd0, 8'h00); ticks(2);
    rd_chk(2'd0, 8'h00, "R5 held no reset");
    key_in = 8'hFF; ticks(4);
    rd_chk(2'd0, 8'h00, "R5 away no set");
    // R9 masking, R7 one-at-a-time clear
    wr(2'd1, 8'h00);
    key_in = 8'hF1; ticks(4);
    chk("R9 masked", {7'd0, irq}, 8'h00);
    rd_chk(2'd0, 8'h0E, "R9 flags set");
    wr(2'd1, 8'hFF);
    chk("R9 enabled", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'hFD); rd_chk(2'd0, 8'h0C, "R7 clear one");
    chk("R7 irq stays", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'hFB); wr(2'd0, 8'hF7);
    chk("R7 irq drops", {7'd0, irq}, 8'h00);
    // R6 reads do not clear
    key_in = 8'hFF; ticks(4);
    key_in = 8'h7F; ticks(4);
    rd_chk(2'd0, 8'h80, "R6 read1");
    rd_chk(2'd0, 8'h80, "R6 read2");
    chk("R6 irq", {7'd0, irq}, 8'h01);
    // R10 clear all
    key_in = 8'h3F; ticks(4);
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h00, "R10 clear all");
    chk("R10 irq", {7'd0, irq}, 8'h00);
    // Random phase against the model (R4..R9)
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(3) == 0) key_in = key_in ^ 8'($urandom_range(255));
      if ($urandom_range(5) == 0) begin
        reg_addr = 2'($urandom_range(3));
        reg_wdata = 8'($urandom_range(255));
        reg_wr = 1'b1;
      end
      if ($urandom_range(2) == 0) begin
        if (!reg_wr) reg_addr = 2'($urandom_range(3));
        reg_rd = 1'b1;
      end
      tick();
    end
    finish_run();
  end
endmodule